// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed instruction into the 32-bit native instruction word that means the same thing. An existing 32-bit execute pipeline can then run the result without changes. Each fetch delivers a 32-bit word that carries two halfwords. A byte-order input picks which of the two halfwords is the current instruction. A second input turns on the encodings that only exist on v5-class cores.

The expander rebuilds each format into its full-width form. It moves register and immediate fields to their native positions, picks a base opcode for the format, scales offsets by the transfer size and folds stack-pointer scaling into the rotate field of the immediate. Branch-class formats are not expanded here, because a separate branch unit computes their targets. The block flags them and passes the raw halfword through. Encodings with no native equivalent raise an undefined flag.

The result is registered. A sample enters when `in_valid` is high, and `out_valid` rises on the next clock edge.

Top module: `halfword_expander`

## Requirements
- R1: When `big_endian` is 1 the current halfword is `fetch_word[31:16]`, otherwise it is `fetch_word[15:0]`. The other halfword has no effect on any output.
- R2: Groups 0-2 (bits [15:11] = 0..2) expand to 0xE1B00000 with the following fields moved:
  - bits [12:11] go to [6:5]
  - bits [10:6] go to [11:7]
  - bits [5:3] go to [3:0]
  - bits [2:0] go to [15:12]

  Group 3 takes its base from bits [10:9]: 0xE0900000, 0xE0500000, 0xE2900000 or 0xE2500000. It then places bits [8:6] at [2:0], bits [5:3] at [19:16] and bits [2:0] at [15:12].
- R3: Groups 4-7 take their base from bits [12:11]: 0xE3B00000, 0xE3500000, 0xE2900000 or 0xE2500000. The 8-bit immediate goes to [7:0], and bits [10:8] go to both [19:16] and [15:12].
- R4: In group 8 with bit 10 clear, bits [9:6] pick one of 16 ALU operations, each with its own base and one of four operand layouts. Here d = bits [2:0] and s = bits [5:3].
  - Normal layout: d goes to [19:16] and [15:12], s goes to [3:0].
  - Shift-by-register layout: d goes to [15:12] and [3:0], s goes to [11:8].
  - Negate layout: d goes to [15:12], s goes to [19:16].
  - Multiply layout: d goes to [19:16] and [11:8], s goes to [3:0].
- R5: In group 8 with bit 10 set, the destination is {bit 7, bits [2:0]} and the source is {bit 6, bits [5:3]}.
  - Sub-ops 1-3 (add, base 0xE0800000), 5-7 (compare, base 0xE1500000) and 9-11 (move, base 0xE1A00000) place the destination at [19:16] and [15:12] and the source at [3:0].
  - Sub-ops 12-13 give 0xE12FFF10 OR bits [6:3].
  - Sub-ops 0, 4 and 8 are undefined.
- R6: v5-only encodings expand only when `v5_en` is 1 and are undefined when it is 0.
  - High-register sub-ops 14-15 give 0xE12FFF30 OR bits [6:3].
  - In group 22-23 with bits [11:8] = 0xE, the result is 0xE1200070 OR (bits [7:4] << 8) OR bits [3:0].
- R7: The address-forming formats are as follows.
  - Group 9 gives 0xE59F0000 with bits [10:8] at [15:12] and the 8-bit immediate shifted left by 2.
  - Groups 18/19 give 0xE58D0000 (store) or 0xE59D0000 (bit 11 set), laid out the same way.
  - Groups 20/21 give 0xE28F0F00 or 0xE28D0F00 (bit 11 set), with bits [10:8] at [15:12] and the immediate unshifted.
- R8: Register-offset transfers (groups 10/11) use bits [11:10] to choose the base. The table is chosen by bit 9.
  - With bit 9 clear: 0xE7800000, 0xE7C00000, 0xE7900000, 0xE7D00000.
  - With bit 9 set: 0xE18000B0, 0xE19000D0, 0xE19000B0, 0xE19000F0.

  In both tables, bits [2:0] go to [15:12], bits [5:3] go to [19:16] and bits [8:6] go to [3:0].
- R9: In groups 12-15 the base comes from bits [12:11]: 0xE5800000, 0xE5900000, 0xE5C00000 or 0xE5D00000. The 5-bit offset (bits [10:6]) is shifted left by 2 when bit 12 is 0 (word) and left unshifted when bit 12 is 1 (byte). In groups 16/17 the base is 0xE1C000B0, or 0xE1D000B0 when bit 11 is set. Offset bits [2:0] go to [3:1] and offset bits [4:3] go to [9:8].
- R10: Groups 22-23 and 24-25 cover the stack and multiple-transfer formats.
  - When bits [11:8] = 0, the result is 0xE28DDF00 OR bits [6:0], or 0xE24DDF00 when bit 7 is set.
  - Push (0x4/0x5) gives 0xE92D0000 OR the list, and 0x5 adds bit 14.
  - Pop (0xC/0xD) gives 0xE8BD0000 OR the list, and 0xD adds bit 15.
  - Groups 24/25 give 0xE8A00000 or 0xE8B00000 (bit 11 set), OR (bits [10:8] << 16) OR the list.
- R11: In groups 26/27, a condition field (bits [11:8]) of 0xF gives 0xEF000000 OR the 8-bit immediate. An immediate of 0x18 is also copied to [23:16]. A condition field of 0xE is undefined.
- R12: The branch-class formats raise `out_branch` and output {16'h0000, halfword}. These are groups 26/27 with a condition field below 0xE, group 28, groups 30 and 31, and group 29 when `v5_en` is 1 and bit 0 is 0.
- R13: Any encoding not listed above raises `out_undef` with `out_word` = 0, for example group 29 with bit 0 set or with `v5_en` = 0, or bits [11:8] = 0x1 in groups 22/23. `out_undef` and `out_branch` are never high together.
- R14: `out_valid` is `in_valid` delayed by one clock. The output fields load only when `in_valid` is high and otherwise hold. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch word is present this cycle |
| fetch_word | input | 32 | Two halfwords from the fetch stage |
| big_endian | input | 1 | 1: current instruction in the upper halfword |
| v5_en | input | 1 | Enables v5-only encodings |
| out_valid | output | 1 | Registered result is valid |
| out_word | output | 32 | Expanded native instruction word |
| out_undef | output | 1 | Halfword has no native equivalent |
| out_branch | output | 1 | Branch-class halfword, passed through raw |

## Verification
- **Halfword selection.** The bench alternates byte order on every vector and fills the other halfword with unrelated bits. It also decodes one fixed fetch word under both orders. A swapped or ignored selector would expand the wrong instruction.
- **Field placement.** Word and byte immediate transfers use the same offset field on purpose. A missing scale, or scaling by the wrong size, would change the offset bits. The split halfword offset checks that the two pieces of the offset land in separate nibbles.
- **v5 gating.** Each v5-only pattern is applied with the feature both on and off. A missing gate would expand when it should raise undefined.
- **Branch and undefined edges.** The neighbouring codes are tested: condition 0xE against 0xF, and group 29 with odd and even bit 0. These catch a branch flag leaking into undefined cases or a breakpoint copy applied to the wrong immediate.

// File: rtl/hwx_pkg.sv
package hwx_pkg;

  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int GRP_W  = 5;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              undef;
    logic              branch;
  } hwx_res_t;

  function automatic hwx_res_t res_undef();
    hwx_res_t r;
    r.word   = '0;
    r.undef  = 1'b1;
    r.branch = 1'b0;
    return r;
  endfunction

  function automatic hwx_res_t res_word(input logic [WORD_W-1:0] w);
    hwx_res_t r;
    r.word   = w;
    r.undef  = 1'b0;
    r.branch = 1'b0;
    return r;
  endfunction

  function automatic hwx_res_t res_branch(input logic [HALF_W-1:0] h);
    hwx_res_t r;
    r.word   = {{(WORD_W-HALF_W){1'b0}}, h};
    r.undef  = 1'b0;
    r.branch = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/hwx_lane_pick.sv
module hwx_lane_pick #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0] fetch_word,
  input  logic            big_endian,
  output logic [HW-1:0]   cur_half
);
  always_comb begin
    if (big_endian) cur_half = fetch_word[2*HW-1:HW];
    else            cur_half = fetch_word[HW-1:0];
  end
endmodule

// File: rtl/hwx_arith_dec.sv
module hwx_arith_dec
  import hwx_pkg::*;
(
  input  logic [HALF_W-1:0] h,
  input  logic              v5_en,
  output hwx_res_t          res
);
  typedef enum logic [1:0] {LAY_NORM, LAY_SHIFT, LAY_NEG, LAY_MUL} lay_e;

  logic [GRP_W-1:0] grp;
  logic [3:0]       alu_op;
  logic [3:0]       hi_d, hi_s;
  logic [31:0]      alu_base;
  lay_e             alu_lay;
  logic [31:0]      d32, s32, rd_hi32, rs_hi32;

  assign grp     = h[15:11];
  assign alu_op  = h[9:6];
  assign hi_d    = {h[7], h[2:0]};
  assign hi_s    = {h[6], h[5:3]};
  assign d32     = 32'(h[2:0]);
  assign s32     = 32'(h[5:3]);
  assign rd_hi32 = 32'(hi_d);
  assign rs_hi32 = 32'(hi_s);

  always_comb begin
    case (alu_op)
      4'h0: begin alu_base = 32'hE0100000; alu_lay = LAY_NORM;  end
      4'h1: begin alu_base = 32'hE0300000; alu_lay = LAY_NORM;  end
      4'h2: begin alu_base = 32'hE1B00010; alu_lay = LAY_SHIFT; end
      4'h3: begin alu_base = 32'hE1B00030; alu_lay = LAY_SHIFT; end
      4'h4: begin alu_base = 32'hE1B00050; alu_lay = LAY_SHIFT; end
      4'h5: begin alu_base = 32'hE0B00000; alu_lay = LAY_NORM;  end
      4'h6: begin alu_base = 32'hE0D00000; alu_lay = LAY_NORM;  end
      4'h7: begin alu_base = 32'hE1B00070; alu_lay = LAY_SHIFT; end
      4'h8: begin alu_base = 32'hE1100000; alu_lay = LAY_NORM;  end
      4'h9: begin alu_base = 32'hE2700000; alu_lay = LAY_NEG;   end
      4'hA: begin alu_base = 32'hE1500000; alu_lay = LAY_NORM;  end
      4'hB: begin alu_base = 32'hE1700000; alu_lay = LAY_NORM;  end
      4'hC: begin alu_base = 32'hE1900000; alu_lay = LAY_NORM;  end
      4'hD: begin alu_base = 32'hE0100090; alu_lay = LAY_MUL;   end
      4'hE: begin alu_base = 32'hE1D00000; alu_lay = LAY_NORM;  end
      default: begin alu_base = 32'hE1F00000; alu_lay = LAY_NORM; end
    endcase
  end

  always_comb begin
    res = res_undef();
    case (grp)
      5'd0, 5'd1, 5'd2:
        res = res_word(32'hE1B00000 | (32'(h[12:11]) << 5) | (32'(h[10:6]) << 7)
                       | s32 | (d32 << 12));
      5'd3: begin
        logic [31:0] b3;
        case (h[10:9])
          2'd0:    b3 = 32'hE0900000;
          2'd1:    b3 = 32'hE0500000;
          2'd2:    b3 = 32'hE2900000;
          default: b3 = 32'hE2500000;
        endcase
        res = res_word(b3 | 32'(h[8:6]) | (s32 << 16) | (d32 << 12));
      end
      5'd4, 5'd5, 5'd6, 5'd7: begin
        logic [31:0] b4;
        case (h[12:11])
          2'd0:    b4 = 32'hE3B00000;
          2'd1:    b4 = 32'hE3500000;
          2'd2:    b4 = 32'hE2900000;
          default: b4 = 32'hE2500000;
        endcase
        res = res_word(b4 | 32'(h[7:0]) | (32'(h[10:8]) << 16) | (32'(h[10:8]) << 12));
      end
      5'd8: begin
        if (!h[10]) begin
          case (alu_lay)
            LAY_NORM:  res = res_word(alu_base | (d32 << 16) | (d32 << 12) | s32);
            LAY_SHIFT: res = res_word(alu_base | (d32 << 12) | d32 | (s32 << 8));
            LAY_NEG:   res = res_word(alu_base | (d32 << 12) | (s32 << 16));
            default:   res = res_word(alu_base | (d32 << 16) | (d32 << 8) | s32);
          endcase
        end else begin
          case (alu_op)
            4'h1, 4'h2, 4'h3:
              res = res_word(32'hE0800000 | (rd_hi32 << 16) | (rd_hi32 << 12) | rs_hi32);
            4'h5, 4'h6, 4'h7:
              res = res_word(32'hE1500000 | (rd_hi32 << 16) | (rd_hi32 << 12) | rs_hi32);
            4'h9, 4'hA, 4'hB:
              res = res_word(32'hE1A00000 | (rd_hi32 << 16) | (rd_hi32 << 12) | rs_hi32);
            4'hC, 4'hD:
              res = res_word(32'hE12FFF10 | 32'(h[6:3]));
            4'hE, 4'hF:
              if (v5_en) res = res_word(32'hE12FFF30 | 32'(h[6:3]));
              else       res = res_undef();
            default: res = res_undef();
          endcase
        end
      end
      default: res = res_undef();
    endcase
  end
endmodule

// File: rtl/hwx_xfer_dec.sv
module hwx_xfer_dec
  import hwx_pkg::*;
(
  input  logic [HALF_W-1:0] h,
  input  logic              v5_en,
  output hwx_res_t          res
);
  logic [GRP_W-1:0] grp;
  logic [31:0]      d32, b32, o32, r8_32, imm8_32, list32;

  assign grp     = h[15:11];
  assign d32     = 32'(h[2:0]);
  assign b32     = 32'(h[5:3]);
  assign o32     = 32'(h[8:6]);
  assign r8_32   = 32'(h[10:8]);
  assign imm8_32 = 32'(h[7:0]);
  assign list32  = imm8_32;

  always_comb begin
    res = res_undef();
    case (grp)
      5'd9:
        res = res_word(32'hE59F0000 | (r8_32 << 12) | (imm8_32 << 2));
      5'd10, 5'd11: begin
        logic [31:0] bt;
        if (!h[9]) begin
          case (h[11:10])
            2'd0:    bt = 32'hE7800000;
            2'd1:    bt = 32'hE7C00000;
            2'd2:    bt = 32'hE7900000;
            default: bt = 32'hE7D00000;
          endcase
        end else begin
          case (h[11:10])
            2'd0:    bt = 32'hE18000B0;
            2'd1:    bt = 32'hE19000D0;
            2'd2:    bt = 32'hE19000B0;
            default: bt = 32'hE19000F0;
          endcase
        end
        res = res_word(bt | (d32 << 12) | (b32 << 16) | o32);
      end
      5'd12, 5'd13, 5'd14, 5'd15: begin
        logic [31:0] bi, off;
        case (h[12:11])
          2'd0:    bi = 32'hE5800000;
          2'd1:    bi = 32'hE5900000;
          2'd2:    bi = 32'hE5C00000;
          default: bi = 32'hE5D00000;
        endcase
        off = h[12] ? 32'(h[10:6]) : (32'(h[10:6]) << 2);
        res = res_word(bi | (d32 << 12) | (b32 << 16) | off);
      end
      5'd16, 5'd17:
        res = res_word((h[11] ? 32'hE1D000B0 : 32'hE1C000B0) | (d32 << 12) | (b32 << 16)
                       | (o32 << 1) | (32'(h[10:9]) << 8));
      5'd18, 5'd19:
        res = res_word((h[11] ? 32'hE59D0000 : 32'hE58D0000) | (r8_32 << 12) | (imm8_32 << 2));
      5'd20, 5'd21:
        res = res_word((h[11] ? 32'hE28D0F00 : 32'hE28F0F00) | (r8_32 << 12) | imm8_32);
      5'd22, 5'd23: begin
        case (h[11:8])
          4'h0: res = res_word((h[7] ? 32'hE24DDF00 : 32'hE28DDF00) | 32'(h[6:0]));
          4'h4: res = res_word(32'hE92D0000 | list32);
          4'h5: res = res_word(32'hE92D4000 | list32);
          4'hC: res = res_word(32'hE8BD0000 | list32);
          4'hD: res = res_word(32'hE8BD8000 | list32);
          4'hE:
            if (v5_en) res = res_word(32'hE1200070 | (32'(h[7:4]) << 8) | 32'(h[3:0]));
            else       res = res_undef();
          default: res = res_undef();
        endcase
      end
      5'd24, 5'd25:
        res = res_word((h[11] ? 32'hE8B00000 : 32'hE8A00000) | (r8_32 << 16) | list32);
      default: res = res_undef();
    endcase
  end
endmodule

// File: rtl/hwx_flow_dec.sv
module hwx_flow_dec
  import hwx_pkg::*;
(
  input  logic [HALF_W-1:0] h,
  input  logic              v5_en,
  output hwx_res_t          res
);
  localparam logic [7:0] DBG_TRAP = 8'h18;
  logic [GRP_W-1:0] grp;
  logic [3:0]       cond;
  logic [31:0]      trap_word;

  assign grp  = h[15:11];
  assign cond = h[11:8];

  always_comb begin
    trap_word = 32'hEF000000 | 32'(h[7:0]);
    if (h[7:0] == DBG_TRAP) trap_word = trap_word | (32'(h[7:0]) << 16);
  end

  always_comb begin
    res = res_undef();
    case (grp)
      5'd26, 5'd27: begin
        if (cond == 4'hF)      res = res_word(trap_word);
        else if (cond == 4'hE) res = res_undef();
        else                   res = res_branch(h);
      end
      5'd28, 5'd30, 5'd31: res = res_branch(h);
      5'd29: begin
        if (v5_en && !h[0]) res = res_branch(h);
        else                res = res_undef();
      end
      default: res = res_undef();
    endcase
  end
endmodule

// File: rtl/halfword_expander.sv
module halfword_expander
  import hwx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] fetch_word,
  input  logic        big_endian,
  input  logic        v5_en,
  output logic        out_valid,
  output logic [31:0] out_word,
  output logic        out_undef,
  output logic        out_branch
);
  localparam logic [GRP_W-1:0] LAST_ARITH = 5'd8;
  localparam logic [GRP_W-1:0] LAST_XFER  = 5'd25;

  logic [HALF_W-1:0] cur;
  hwx_res_t          r_arith, r_xfer, r_flow, sel_res;
  hwx_res_t          res_q, res_d;
  logic              vld_q, vld_d;

  hwx_lane_pick #(.HW(HALF_W)) u_pick (
    .fetch_word (fetch_word),
    .big_endian (big_endian),
    .cur_half   (cur)
  );

  hwx_arith_dec u_arith (.h(cur), .v5_en(v5_en), .res(r_arith));
  hwx_xfer_dec  u_xfer  (.h(cur), .v5_en(v5_en), .res(r_xfer));
  hwx_flow_dec  u_flow  (.h(cur), .v5_en(v5_en), .res(r_flow));

  always_comb begin
    if (cur[15:11] <= LAST_ARITH)     sel_res = r_arith;
    else if (cur[15:11] <= LAST_XFER) sel_res = r_xfer;
    else                              sel_res = r_flow;
  end

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) res_d = sel_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_word   = res_q.word;
  assign out_undef  = res_q.undef;
  assign out_branch = res_q.branch;
endmodule

// File: rtl/hwx_expander_chk.sv
module hwx_expander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] fetch_word,
  input logic        big_endian,
  input logic        v5_en,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic        out_undef,
  input logic        out_branch
);
  logic [15:0] cur_h;
  assign cur_h = big_endian ? fetch_word[31:16] : fetch_word[15:0];

  // R14
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R14
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R14
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word) && $stable(out_undef) && $stable(out_branch));
  // R13
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> out_word == 32'h0);
  // R13
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_undef && out_branch));
  // R12
  branch_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_branch |-> out_word[31:16] == 16'h0);
  // R6
  bkpt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !v5_en && cur_h[15:8] == 8'hBE) |=> out_undef);
endmodule

bind halfword_expander hwx_expander_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .fetch_word (fetch_word),
  .big_endian (big_endian),
  .v5_en      (v5_en),
  .out_valid  (out_valid),
  .out_word   (out_word),
  .out_undef  (out_undef),
  .out_branch (out_branch)
);

// File: tb/tb_halfword_expander.sv
`timescale 1ns/1ps
module tb_halfword_expander;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] fetch_word;
  logic        big_endian;
  logic        v5_en;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_undef;
  logic        out_branch;

  int n_chk  = 0;
  int n_fail = 0;

  halfword_expander dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fetch_word(fetch_word),
    .big_endian(big_endian), .v5_en(v5_en), .out_valid(out_valid),
    .out_word(out_word), .out_undef(out_undef), .out_branch(out_branch)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {halfword, v5, expected word, undef, branch}
  localparam int NV = 44;
  localparam logic [50:0] VEC [NV] = '{
    {16'h00D1, 1'b0, 32'hE1B01182, 1'b0, 1'b0}, // R2
    {16'h105C, 1'b0, 32'hE1B040C3, 1'b0, 1'b0}, // R2
    {16'h1F53, 1'b0, 32'hE2523005, 1'b0, 1'b0}, // R2
    {16'h20FF, 1'b0, 32'hE3B000FF, 1'b0, 1'b0}, // R3
    {16'h2A7F, 1'b0, 32'hE352207F, 1'b0, 1'b0}, // R3
    {16'h435D, 1'b0, 32'hE0150593, 1'b0, 1'b0}, // R4
    {16'h41D6, 1'b0, 32'hE1B06276, 1'b0, 1'b0}, // R4
    {16'h4279, 1'b0, 32'hE2771000, 1'b0, 1'b0}, // R4
    {16'h4062, 1'b0, 32'hE0322004, 1'b0, 1'b0}, // R4
    {16'h46CA, 1'b0, 32'hE1AAA009, 1'b0, 1'b0}, // R5
    {16'h4473, 1'b0, 32'hE083300E, 1'b0, 1'b0}, // R5
    {16'h4728, 1'b0, 32'hE12FFF15, 1'b0, 1'b0}, // R5
    {16'h4400, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R5
    {16'h4798, 1'b1, 32'hE12FFF33, 1'b0, 1'b0}, // R6
    {16'h4798, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R6
    {16'h4B10, 1'b0, 32'hE59F3040, 1'b0, 1'b0}, // R7
    {16'h95CC, 1'b0, 32'hE58D5330, 1'b0, 1'b0}, // R7
    {16'hAE03, 1'b0, 32'hE28D6F03, 1'b0, 1'b0}, // R7
    {16'hA1FF, 1'b0, 32'hE28F1FFF, 1'b0, 1'b0}, // R7
    {16'h5C88, 1'b0, 32'hE7D10002, 1'b0, 1'b0}, // R8
    {16'h5E5F, 1'b0, 32'hE19370F1, 1'b0, 1'b0}, // R8
    {16'h5200, 1'b0, 32'hE18000B0, 1'b0, 1'b0}, // R8
    {16'h6953, 1'b0, 32'hE5923014, 1'b0, 1'b0}, // R9
    {16'h7953, 1'b0, 32'hE5D23005, 1'b0, 1'b0}, // R9
    {16'h8EE1, 1'b0, 32'hE1D413B6, 1'b0, 1'b0}, // R9
    {16'hB085, 1'b0, 32'hE24DDF05, 1'b0, 1'b0}, // R10
    {16'hB5F0, 1'b0, 32'hE92D40F0, 1'b0, 1'b0}, // R10
    {16'hBD03, 1'b0, 32'hE8BD8003, 1'b0, 1'b0}, // R10
    {16'hBC81, 1'b0, 32'hE8BD0081, 1'b0, 1'b0}, // R10
    {16'hCA55, 1'b0, 32'hE8B20055, 1'b0, 1'b0}, // R10
    {16'hC7FF, 1'b0, 32'hE8A700FF, 1'b0, 1'b0}, // R10
    {16'hBEAB, 1'b1, 32'hE1200A7B, 1'b0, 1'b0}, // R6
    {16'hBEAB, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R6
    {16'hB100, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R13
    {16'hDF18, 1'b0, 32'hEF180018, 1'b0, 1'b0}, // R11
    {16'hDF42, 1'b0, 32'hEF000042, 1'b0, 1'b0}, // R11
    {16'hDE01, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R11
    {16'hD0FE, 1'b0, 32'h0000D0FE, 1'b0, 1'b1}, // R12
    {16'hE123, 1'b0, 32'h0000E123, 1'b0, 1'b1}, // R12
    {16'hE802, 1'b1, 32'h0000E802, 1'b0, 1'b1}, // R12
    {16'hE802, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R13
    {16'hE803, 1'b1, 32'h00000000, 1'b1, 1'b0}, // R13
    {16'hF000, 1'b0, 32'h0000F000, 1'b0, 1'b1}, // R12
    {16'hF801, 1'b0, 32'h0000F801, 1'b0, 1'b1}  // R12
  };

  task automatic check(input string tag, input logic ev, input logic [31:0] ew,
                       input logic eu, input logic eb);
    n_chk++;
    if (out_valid !== ev || out_word !== ew || out_undef !== eu || out_branch !== eb) begin
      n_fail++;
      $display("FAIL %s: got v=%0b w=%08h u=%0b b=%0b, expected v=%0b w=%08h u=%0b b=%0b",
               tag, out_valid, out_word, out_undef, out_branch, ev, ew, eu, eb);
    end
  endtask

  // drive at a falling edge, result visible at the next falling edge
  task automatic apply(input logic [31:0] fw, input logic be, input logic v5);
    in_valid   = 1'b1;
    fetch_word = fw;
    big_endian = be;
    v5_en      = v5;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; fetch_word = '0; big_endian = 1'b0; v5_en = 1'b0;
    repeat (3) @(negedge clk);
    // R14: reset state
    check("R14 reset", 1'b0, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R14 idle after reset", 1'b0, 32'h0, 1'b0, 1'b0);

    // table walk; R1: byte order alternates, other halfword is noise
    for (int i = 0; i < NV; i++) begin
      logic [15:0] h, other;
      logic        be;
      h     = VEC[i][50:35];
      other = ~h ^ 16'h5A5A;
      be    = i[0];
      apply(be ? {h, other} : {other, h}, be, VEC[i][34]);
      check($sformatf("R1 vector %0d h=%04h", i, h), 1'b1, VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end

    // R1: the same fetch word decoded under both byte orders
    apply({16'h00D1, 16'h4B10}, 1'b1, 1'b0);
    check("R1 upper lane", 1'b1, 32'hE1B01182, 1'b0, 1'b0);
    apply({16'h00D1, 16'h4B10}, 1'b0, 1'b0);
    check("R1 lower lane", 1'b1, 32'hE59F3040, 1'b0, 1'b0);

    // R14: outputs hold while in_valid is low
    in_valid = 1'b0; fetch_word = 32'hDF18DF18; big_endian = 1'b1;
    @(negedge clk);
    check("R14 hold", 1'b0, 32'hE59F3040, 1'b0, 1'b0);
    @(negedge clk);
    check("R14 hold second cycle", 1'b0, 32'hE59F3040, 1'b0, 1'b0);

    // R13: undefined after a valid word clears it to zero
    apply(32'h0000B100, 1'b0, 1'b1);
    check("R13 undef after word", 1'b1, 32'h0, 1'b1, 1'b0);

    // R11: trap immediate one off the copied value
    apply(32'hDF190000, 1'b1, 1'b0);
    check("R11 plain trap", 1'b1, 32'hEF000019, 1'b0, 1'b0);

    // R14: reset mid-stream clears outputs
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R14 reset mid-stream", 1'b0, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule